// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block decides when a memory device copies its fast SRAM array into the shadow nonvolatile array (a store) and when it copies the shadow array back (a recall). It watches four things: a power-fail flag from a supply comparator, an active-low hardware store pin, software store and recall pulses from an address-sequence detector, and a strobe from the bus interface that marks each finished write. It drives a modelled nonvolatile array with erase, program and recall commands. Each command is held for a number of clock cycles set by a parameter. While any transfer runs, or while the device is parked, it holds an SRAM-disable line high so the bus interface refuses reads and writes.

A store is an erase phase followed by a program phase. Stores caused by the pin or by a power failure are skipped when no write has landed since the last store. A software store always runs. After a power failure the device stays disabled and keeps a recall pending. That recall runs once the supply recovers. Leaving reset counts as a power-up and is handled the same way.

Top module: `nv_xfer_seq`

## Requirements
- R1: During reset and afterwards while `pwr_low` is 1, `sram_dis` is 1 and no command is issued. Once `pwr_low` is 0, `nv_recall` is high for exactly RESTORE_CYC cycles and `sram_dis` then returns to 0.
- R2: A store holds `nv_erase` high for exactly ERASE_CYC cycles and then `nv_program` high for exactly PROG_CYC cycles, with no gap between them. At most one command is high at a time, and `sram_dis` is 1 whenever a command is high.
- R3: A `sw_store_req` pulse in the idle state starts a store even when no write is pending.
- R4: When `hw_store_n` goes to 0 with no write pending, no store runs. `sram_dis` stays 1 until the pin returns to 1.
- R5: When `hw_store_n` goes to 0 with a write pending, a store runs. If the pin is still 0 when the store ends, `sram_dis` stays 1 with no second store until the pin returns to 1.
- R6: When `pwr_low` rises in the idle state, a store runs only if a write is pending. In both cases the device then stays disabled with no command until `pwr_low` falls, and a recall of RESTORE_CYC cycles follows.
- R7: A `sw_recall_req` pulse in the idle state starts a recall of RESTORE_CYC cycles.
- R8: `xfer_done` is a one-cycle pulse in the cycle right after the last program cycle or the last recall cycle.
- R9: `wr_pending` is set by `wr_done` in the idle state. It is cleared when a store or a recall completes. A `wr_done` that arrives while the block is not idle is ignored.
- R10: Software store and recall pulses that arrive while a transfer runs are ignored.
- R11: When triggers arrive in the same idle cycle, the order of priority is `pwr_low`, then `hw_store_n`, then `sw_store_req`, then `sw_recall_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, treated as power-up |
| pwr_low | input | 1 | 1 while the supply is below the switch threshold |
| hw_store_n | input | 1 | Hardware store pin, active low (level) |
| sw_store_req | input | 1 | One-cycle software store request |
| sw_recall_req | input | 1 | One-cycle software recall request |
| wr_done | input | 1 | One-cycle strobe for each completed SRAM write |
| sram_dis | output | 1 | 1 while SRAM reads and writes are blocked |
| nv_erase | output | 1 | Erase command to the nonvolatile array |
| nv_program | output | 1 | Program command to the nonvolatile array |
| nv_recall | output | 1 | Recall command to the nonvolatile array |
| xfer_done | output | 1 | End-of-transfer pulse |
| wr_pending | output | 1 | A write has landed since the last store or recall |

## Verification
A wrong write-pending flag shows up as a store that runs or is skipped against the rules. The erase line gives this away in the first cycle after the pin or power trigger. A timer that is off by one makes a command window one cycle too long or too short. A wrong return state after a store shows as `sram_dis` falling while the pin or the power flag still holds it, or as a recall that never starts once the supply recovers. All of these appear within one transfer length of the trigger.

// File: rtl/nv_seq_pkg.sv
package nv_seq_pkg;

  typedef enum logic [2:0] {
    ST_WAITPWR,
    ST_IDLE,
    ST_ERASE,
    ST_PROG,
    ST_RECALL,
    ST_PINHOLD
  } seq_state_t;

  typedef enum logic [1:0] {
    GO_IDLE,
    GO_WAITPWR,
    GO_PINHOLD
  } after_t;

  typedef struct packed {
    logic   do_store;
    logic   do_recall;
    after_t next;
  } action_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int timer_width(input int a, input int b, input int c);
    return $clog2(max3(a, b, c) + 1);
  endfunction

endpackage

// File: rtl/nv_trigger_arb.sv
module nv_trigger_arb
  import nv_seq_pkg::*;
(
  input  logic    pwr_low,
  input  logic    hw_store_n,
  input  logic    sw_store_req,
  input  logic    sw_recall_req,
  input  logic    dirty_eff,
  output action_t act
);

  always_comb begin
    act.do_store  = 1'b0;
    act.do_recall = 1'b0;
    act.next      = GO_IDLE;
    if (pwr_low) begin
      act.do_store = dirty_eff;
      act.next     = GO_WAITPWR;
    end else if (!hw_store_n) begin
      act.do_store = dirty_eff;
      act.next     = GO_PINHOLD;
    end else if (sw_store_req) begin
      act.do_store = 1'b1;
    end else if (sw_recall_req) begin
      act.do_recall = 1'b1;
    end
  end

endmodule

// File: rtl/nv_phase_timer.sv
module nv_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         last
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= len - W'(1);
    else if (cnt != '0)
      cnt <= cnt - W'(1);
  end

  assign last = (cnt == '0);

  assert_len_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (len != '0));

endmodule

// File: rtl/nv_dirty_track.sv
module nv_dirty_track (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic wr_done,
  input  logic clr,
  output logic dirty
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dirty <= 1'b0;
    else if (clr)
      dirty <= 1'b0;
    else if (accept && wr_done)
      dirty <= 1'b1;
  end

  assert_set_only_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dirty) |-> $past(accept && wr_done));

  assert_clear_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !dirty);

endmodule

// File: rtl/nv_xfer_seq.sv
module nv_xfer_seq
  import nv_seq_pkg::*;
#(
  parameter int ERASE_CYC   = 8,
  parameter int PROG_CYC    = 16,
  parameter int RESTORE_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_low,
  input  logic hw_store_n,
  input  logic sw_store_req,
  input  logic sw_recall_req,
  input  logic wr_done,
  output logic sram_dis,
  output logic nv_erase,
  output logic nv_program,
  output logic nv_recall,
  output logic xfer_done,
  output logic wr_pending
);

  localparam int TW = timer_width(ERASE_CYC, PROG_CYC, RESTORE_CYC);
  localparam logic [TW-1:0] LEN_ERASE   = TW'(ERASE_CYC);
  localparam logic [TW-1:0] LEN_PROG    = TW'(PROG_CYC);
  localparam logic [TW-1:0] LEN_RESTORE = TW'(RESTORE_CYC);

  seq_state_t state, state_nx;
  after_t     after_q, after_nx;
  action_t    act;
  logic       is_idle;
  logic       t_load, t_last;
  logic [TW-1:0] t_len;
  logic       store_end, recall_end, xfer_end;
  logic       done_q;

  assign is_idle = (state == ST_IDLE);

  nv_trigger_arb u_arb (
    .pwr_low      (pwr_low),
    .hw_store_n   (hw_store_n),
    .sw_store_req (sw_store_req),
    .sw_recall_req(sw_recall_req),
    .dirty_eff    (wr_pending | wr_done),
    .act          (act)
  );

  nv_phase_timer #(.W(TW)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .load (t_load),
    .len  (t_len),
    .last (t_last)
  );

  assign store_end  = (state == ST_PROG)   && t_last;
  assign recall_end = (state == ST_RECALL) && t_last;
  assign xfer_end   = store_end || recall_end;

  nv_dirty_track u_dirty (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (is_idle),
    .wr_done(wr_done),
    .clr    (xfer_end),
    .dirty  (wr_pending)
  );

  always_comb begin
    state_nx = state;
    after_nx = after_q;
    t_load   = 1'b0;
    t_len    = LEN_ERASE;
    unique case (state)
      ST_WAITPWR: begin
        if (!pwr_low) begin
          state_nx = ST_RECALL;
          t_load   = 1'b1;
          t_len    = LEN_RESTORE;
        end
      end
      ST_IDLE: begin
        if (act.do_store) begin
          state_nx = ST_ERASE;
          after_nx = act.next;
          t_load   = 1'b1;
          t_len    = LEN_ERASE;
        end else if (act.do_recall) begin
          state_nx = ST_RECALL;
          t_load   = 1'b1;
          t_len    = LEN_RESTORE;
        end else if (act.next == GO_WAITPWR) begin
          state_nx = ST_WAITPWR;
        end else if (act.next == GO_PINHOLD) begin
          state_nx = ST_PINHOLD;
        end
      end
      ST_ERASE: begin
        if (t_last) begin
          state_nx = ST_PROG;
          t_load   = 1'b1;
          t_len    = LEN_PROG;
        end
      end
      ST_PROG: begin
        if (t_last) begin
          unique case (after_q)
            GO_WAITPWR: state_nx = ST_WAITPWR;
            GO_PINHOLD: state_nx = ST_PINHOLD;
            default:    state_nx = ST_IDLE;
          endcase
        end
      end
      ST_RECALL: begin
        if (t_last) state_nx = ST_IDLE;
      end
      ST_PINHOLD: begin
        if (hw_store_n) state_nx = ST_IDLE;
      end
      default: state_nx = ST_WAITPWR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_WAITPWR;
      after_q <= GO_IDLE;
      done_q  <= 1'b0;
    end else begin
      state   <= state_nx;
      after_q <= after_nx;
      done_q  <= xfer_end;
    end
  end

  assign sram_dis   = !is_idle;
  assign nv_erase   = (state == ST_ERASE);
  assign nv_program = (state == ST_PROG);
  assign nv_recall  = (state == ST_RECALL);
  assign xfer_done  = done_q;

  assert_one_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nv_erase, nv_program, nv_recall}));

  assert_cmd_blocks_sram_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_erase || nv_program || nv_recall) |-> sram_dis);

  assert_erase_then_prog_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nv_erase) |-> nv_program);

  assert_store_needs_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(nv_erase) && !$past(sw_store_req)) |-> $past(wr_pending || wr_done));

  assert_recall_needs_power_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nv_recall) |-> !$past(pwr_low));

  assert_done_follows_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> ($past(nv_program) || $past(nv_recall)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

endmodule

// File: tb/nv_xfer_seq_test.sv
module nv_xfer_seq_test;

  localparam int EC = 4;
  localparam int PC = 6;
  localparam int RC = 5;

  logic clk = 1'b0;
  logic rst_n, pwr_low, hw_store_n, sw_store_req, sw_recall_req, wr_done;
  logic sram_dis, nv_erase, nv_program, nv_recall, xfer_done, wr_pending;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  nv_xfer_seq #(.ERASE_CYC(EC), .PROG_CYC(PC), .RESTORE_CYC(RC)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_low(pwr_low), .hw_store_n(hw_store_n),
    .sw_store_req(sw_store_req), .sw_recall_req(sw_recall_req), .wr_done(wr_done),
    .sram_dis(sram_dis), .nv_erase(nv_erase), .nv_program(nv_program),
    .nv_recall(nv_recall), .xfer_done(xfer_done), .wr_pending(wr_pending)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic pick(input int w);
    case (w)
      0: return nv_erase;
      1: return nv_program;
      2: return nv_recall;
      default: return sram_dis;
    endcase
  endfunction

  task automatic measure(input int w, output int n);
    n = 0;
    while (pick(w) === 1'b1 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_write();
    wr_done = 1'b1;
    @(negedge clk);
    wr_done = 1'b0;
  endtask

  // trigger already driven; checks a full store
  task automatic expect_store(input string req);
    int n;
    @(negedge clk);
    sw_store_req = 1'b0; sw_recall_req = 1'b0;
    chk(req, "erase starts", nv_erase, 1);
    measure(0, n);
    chk("R2", "erase length", n, EC);
    measure(1, n);
    chk("R2", "program length", n, PC);
    chk("R8", "done after store", xfer_done, 1);
  endtask

  task automatic expect_recall(input string req);
    int n;
    measure(2, n);
    chk(req, "recall length", n, RC);
    chk("R8", "done after recall", xfer_done, 1);
  endtask

  task automatic t_powerup();
    rst_n = 1'b0; pwr_low = 1'b1; hw_store_n = 1'b1;
    sw_store_req = 1'b0; sw_recall_req = 1'b0; wr_done = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "dis in reset", sram_dis, 1);
    chk("R1", "no recall in reset", nv_recall, 0);
    chk("R9", "pending reset", wr_pending, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1", "held while low", sram_dis, 1);
    chk("R1", "no recall while low", nv_recall, 0);
    pwr_low = 1'b0;
    @(negedge clk);
    expect_recall("R1");
    chk("R1", "sram enabled", sram_dis, 0);
    @(negedge clk);
    chk("R8", "done single", xfer_done, 0);
  endtask

  task automatic t_sw_store_clean();
    sw_store_req = 1'b1;
    expect_store("R3");
    chk("R3", "idle after", sram_dis, 0);
    @(negedge clk);
  endtask

  task automatic t_pin_clean();
    hw_store_n = 1'b0;
    @(negedge clk);
    chk("R4", "no erase", nv_erase, 0);
    chk("R4", "disabled", sram_dis, 1);
    repeat (5) @(negedge clk);
    chk("R4", "still no erase", nv_erase, 0);
    chk("R4", "still disabled", sram_dis, 1);
    hw_store_n = 1'b1;
    @(negedge clk);
    chk("R4", "released", sram_dis, 0);
  endtask

  task automatic t_pin_dirty();
    do_write();
    chk("R9", "write sets pending", wr_pending, 1);
    hw_store_n = 1'b0;
    expect_store("R5");
    chk("R9", "store clears", wr_pending, 0);
    chk("R5", "hold after store", sram_dis, 1);
    repeat (4) @(negedge clk);
    chk("R5", "no second store", nv_erase, 0);
    chk("R5", "still held", sram_dis, 1);
    hw_store_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R5", "released", sram_dis, 0);
  endtask

  task automatic t_pwr_clean();
    pwr_low = 1'b1;
    @(negedge clk);
    chk("R6", "no erase clean", nv_erase, 0);
    repeat (4) @(negedge clk);
    chk("R6", "disabled", sram_dis, 1);
    chk("R6", "no recall", nv_recall, 0);
    pwr_low = 1'b0;
    @(negedge clk);
    expect_recall("R6");
    chk("R6", "back idle", sram_dis, 0);
  endtask

  task automatic t_pwr_dirty();
    do_write();
    pwr_low = 1'b1;
    expect_store("R6");
    repeat (3) @(negedge clk);
    chk("R6", "waiting", sram_dis, 1);
    chk("R6", "recall held", nv_recall, 0);
    pwr_low = 1'b0;
    @(negedge clk);
    expect_recall("R6");
    chk("R9", "pending cleared", wr_pending, 0);
  endtask

  task automatic t_sw_recall();
    do_write();
    sw_recall_req = 1'b1;
    @(negedge clk);
    sw_recall_req = 1'b0;
    expect_recall("R7");
    chk("R9", "recall clears", wr_pending, 0);
    @(negedge clk);
  endtask

  task automatic t_busy_ignore();
    int n;
    do_write();
    sw_store_req = 1'b1;
    @(negedge clk);
    sw_store_req = 1'b0;
    sw_recall_req = 1'b1; wr_done = 1'b1;
    @(negedge clk);
    sw_recall_req = 1'b0; wr_done = 1'b0;
    measure(0, n);
    measure(1, n);
    chk("R9", "busy write ignored", wr_pending, 0);
    repeat (3) @(negedge clk);
    chk("R10", "no recall", nv_recall, 0);
    chk("R10", "idle", sram_dis, 0);
  endtask

  task automatic t_priority();
    sw_store_req = 1'b1; sw_recall_req = 1'b1;
    expect_store("R11");
    @(negedge clk);
    pwr_low = 1'b1; sw_store_req = 1'b1;
    @(negedge clk);
    sw_store_req = 1'b0;
    chk("R11", "power beats software", nv_erase, 0);
    chk("R11", "parked", sram_dis, 1);
    pwr_low = 1'b0;
    @(negedge clk);
    expect_recall("R11");
  endtask

  initial begin
    t_powerup();
    t_sw_store_clean();
    t_pin_clean();
    t_pin_dirty();
    t_pwr_clean();
    t_pwr_dirty();
    t_sw_recall();
    t_busy_ignore();
    t_priority();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule